// File: doc/BRIEF.md
# Two-Class Level Interrupt Controller

This block gathers level-sensitive interrupt lines from peripherals and presents them to a processor as two active-low request wires: a fast request and a normal request. Line 0 is reserved for the fast class; every other line belongs to the normal class. Each class has a raw status word that samples the lines every cycle, an enable word, and a status word equal to raw AND enable. A request wire is asserted whenever its class status is non-zero. A software-controlled bit lets a program raise a normal interrupt itself.

Software reaches the registers through a simple single-master bus slave. The master raises a select with address, direction and write data, and holds them until the ready output goes high. Ready stays low for a fixed number of wait cycles, set by a parameter in the range 0 to 30. Enables are changed only through a set word and a clear word, so no read-modify-write is needed. The block does not vector, prioritise, nest or detect edges. Software reads status and services the lines.

Top module: `irqc_top`

## Requirements
- R1: After a clock edge with `rst_n` low, both request outputs are high (deasserted), and every register reads 0.
- R2: Line 0 alone feeds the fast raw status, which reads at byte offset 0x104 bit 0. Normal raw status bit 0 always reads 0.
- R3: Normal raw status (offset 0x004) bit n, for n from 1 to NSRC-1, equals the level of line n one clock edge earlier, with no latching.
- R4: Normal status (offset 0x000) equals normal raw AND normal enable (offset 0x008). `irq_n_o` is low exactly when the normal status sampled at the previous edge was non-zero.
- R5: Fast status (offset 0x100, bit 0) equals fast raw AND fast enable (offset 0x108, bit 0). `fiq_n_o` is low exactly when the fast status at the previous edge was 1.
- R6: Writing to the enable offset (0x008, or 0x108 for the fast class) ORs the write data into the enable. Writing to the clear offset (0x00C, or 0x10C) clears the enable bits where the data is 1. Clear offsets read as 0. Normal enable bit 0 stays 0.
- R7: Bit 1 of a write to the soft offset 0x010 sets or clears the soft bit, and the soft bit is ORed into normal raw bit 1. Offset 0x010 reads the soft bit back at bit 1.
- R8: An access completes in the cycle that `bus_ready_o` is high. Ready stays low for exactly WAITS cycles after select rises, then goes high.
- R9: A WAITS value outside 0..30 gives zero wait states.
- R10: Reads of unmapped offsets in the window return 0, and writes to them change no register.
- R11: When a source line changes, the matching request output changes two clock edges later: one edge into raw status and one into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Level interrupt lines, line 0 is the fast source |
| bus_sel_i | input | 1 | Access select, held until ready |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte address within the 0x110-byte window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while ready is high |
| bus_ready_o | output | 1 | Access completes this cycle |
| irq_n_o | output | 1 | Normal interrupt request, active low, registered |
| fiq_n_o | output | 1 | Fast interrupt request, active low, registered |

## Verification
Every cycle, the assertions check that raw status follows the previous cycle's line levels and that each request output matches the previous cycle's masked status. They also check that a clear write leaves no enable bit set where the data had a 1, and that ready rises only after exactly the programmed number of wait cycles. Other behaviour is shown only by the bench's scenarios. These scenarios cover the OR and AND-NOT behaviour of the set and clear words and the soft bit ORed with a live line. They also cover unmapped offsets, the fallback for an out-of-range wait count, and the exact two-edge latency. A sweep of all 256 line patterns against several enable masks supplies the value coverage.

// File: rtl/irqc_pkg.sv
// Package: shared constants and helpers for the two-class interrupt controller.
// Assumes a 9-bit byte address and word-aligned register offsets.
package irqc_pkg;

    localparam int DW      = 32;   // bus data width
    localparam int AW      = 9;    // byte address width of the window
    localparam int WORD_AW = AW - 2;
    localparam int CNT_W   = 5;    // wide enough for 30 wait states
    localparam int MAX_WAITS = 30;
    localparam int SOFT_BIT  = 1;

    // Word indices of the registers (byte offset / 4)
    localparam logic [WORD_AW-1:0] W_NSTAT = 7'h00;
    localparam logic [WORD_AW-1:0] W_NRAW  = 7'h01;
    localparam logic [WORD_AW-1:0] W_NEN   = 7'h02;
    localparam logic [WORD_AW-1:0] W_NCLR  = 7'h03;
    localparam logic [WORD_AW-1:0] W_NSOFT = 7'h04;
    localparam logic [WORD_AW-1:0] W_FSTAT = 7'h40;
    localparam logic [WORD_AW-1:0] W_FRAW  = 7'h41;
    localparam logic [WORD_AW-1:0] W_FEN   = 7'h42;
    localparam logic [WORD_AW-1:0] W_FCLR  = 7'h43;

    // Map a requested wait count to the one actually used.
    function automatic int clamp_waits(input int req);
        return (req < 0 || req > MAX_WAITS) ? 0 : req;
    endfunction

endpackage

// File: rtl/irqc_wait_seq.sv
// Module: irqc_wait_seq
// Stretches every bus access by a fixed number of wait cycles.
// Assumes the master holds select until ready is seen high.
module irqc_wait_seq
    import irqc_pkg::*;
#(
    parameter int WAITS_EFF = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic ready_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAITS_EFF);

    logic [CNT_W-1:0] cnt_q;

    // Ready once the counter has reached the wait limit.
    assign ready_o = sel_i && (cnt_q == LIMIT);

    // Count wait cycles of the access in progress; restart when idle or done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sel_i && !ready_o)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

endmodule

// File: rtl/irqc_norm_bank.sv
// Module: irqc_norm_bank
// Normal-class registers: raw status sampled from lines 1..NSRC-1 plus
// the soft bit, enable with set/clear strobes, and masked status.
// Assumes NSRC >= 2 so that the soft bit position exists.
module irqc_norm_bank
    import irqc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:1] lines_i,
    input  logic            set_we_i,
    input  logic            clr_we_i,
    input  logic            soft_we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] stat_o,
    output logic            soft_o
);

    logic [NSRC-1:0] raw_d;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] en_q;
    logic            soft_q;

    // Lane 0 never carries a normal source.
    assign raw_d[0] = 1'b0;

    // Build each raw lane from its line, ORing the soft bit into its lane.
    for (genvar k = 1; k < NSRC; k++) begin : g_lane
        if (k == SOFT_BIT) begin : g_soft
            assign raw_d[k] = lines_i[k] | soft_q;
        end else begin : g_plain
            assign raw_d[k] = lines_i[k];
        end
    end

    // Sample line levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    // Enable: set ORs in, clear removes; lane 0 held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (set_we_i)
            en_q <= (en_q | wdata_i) & ~NSRC'(1);
        else if (clr_we_i)
            en_q <= en_q & ~wdata_i;
    end

    // Soft-interrupt bit under program control.
    always_ff @(posedge clk) begin
        if (!rst_n)         soft_q <= 1'b0;
        else if (soft_we_i) soft_q <= wdata_i[SOFT_BIT];
    end

    assign raw_o  = raw_q;
    assign en_o   = en_q;
    assign stat_o = raw_q & en_q;
    assign soft_o = soft_q;

endmodule

// File: rtl/irqc_fast_bank.sv
// Module: irqc_fast_bank
// Fast-class registers: one-bit raw status sampled from line 0, one-bit
// enable with set/clear strobes, and masked status.
// Assumes only data bit 0 is meaningful for this class.
module irqc_fast_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic set_we_i,
    input  logic clr_we_i,
    input  logic wbit_i,
    output logic raw_o,
    output logic en_o,
    output logic stat_o
);

    logic raw_q;
    logic en_q;

    // Sample the fast line every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= line_i;
    end

    // Enable bit: set on a 1 to the set word, cleared by a 1 to the clear word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (set_we_i && wbit_i)
            en_q <= 1'b1;
        else if (clr_we_i && wbit_i)
            en_q <= 1'b0;
    end

    assign raw_o  = raw_q;
    assign en_o   = en_q;
    assign stat_o = raw_q & en_q;

endmodule

// File: rtl/irqc_req_drv.sv
// Module: irqc_req_drv
// Registers an active-high request level into an active-low output, so
// the wire to the processor changes only on clock edges.
module irqc_req_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic req_n_o
);

    logic req_n_q;

    // Hold the request deasserted in reset; otherwise follow the level.
    always_ff @(posedge clk) begin
        if (!rst_n) req_n_q <= 1'b1;
        else        req_n_q <= ~active_i;
    end

    assign req_n_o = req_n_q;

endmodule

// File: rtl/irqc_top.sv
// Module: irqc_top
// Two-class level interrupt controller with a wait-stated register bus.
// Line 0 feeds only the fast class; lines 1..NSRC-1 feed the normal class.
// Assumes NSRC is between 2 and 32 and the master holds each access
// steady until ready is high.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int WAITS = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_sel_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic            bus_ready_o,
    output logic            irq_n_o,
    output logic            fiq_n_o
);

    localparam int WAITS_EFF = clamp_waits(WAITS);

    logic [WORD_AW-1:0] widx;
    logic               wr_go;
    logic [NSRC-1:0]    nraw_w, nen_w, nstat_w;
    logic               soft_w;
    logic               fraw_w, fen_w, fstat_w;
    logic [1:0]         unused_addr_lo;
    logic [DW-1:0]      unused_wdata;

    assign widx           = bus_addr_i[AW-1:2];
    assign unused_addr_lo = bus_addr_i[1:0];
    assign unused_wdata   = bus_wdata_i;
    assign wr_go          = bus_sel_i && bus_wr_i && bus_ready_o;

    irqc_wait_seq #(.WAITS_EFF(WAITS_EFF)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (bus_sel_i),
        .ready_o (bus_ready_o)
    );

    irqc_norm_bank #(.NSRC(NSRC)) u_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_i   (src_i[NSRC-1:1]),
        .set_we_i  (wr_go && widx == W_NEN),
        .clr_we_i  (wr_go && widx == W_NCLR),
        .soft_we_i (wr_go && widx == W_NSOFT),
        .wdata_i   (bus_wdata_i[NSRC-1:0]),
        .raw_o     (nraw_w),
        .en_o      (nen_w),
        .stat_o    (nstat_w),
        .soft_o    (soft_w)
    );

    irqc_fast_bank u_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (src_i[0]),
        .set_we_i (wr_go && widx == W_FEN),
        .clr_we_i (wr_go && widx == W_FCLR),
        .wbit_i   (bus_wdata_i[0]),
        .raw_o    (fraw_w),
        .en_o     (fen_w),
        .stat_o   (fstat_w)
    );

    irqc_req_drv u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (|nstat_w),
        .req_n_o  (irq_n_o)
    );

    irqc_req_drv u_fiq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (fstat_w),
        .req_n_o  (fiq_n_o)
    );

    // Read multiplexer: readable words by index, everything else zero.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            case (widx)
                W_NSTAT: bus_rdata_o = DW'(nstat_w);
                W_NRAW:  bus_rdata_o = DW'(nraw_w);
                W_NEN:   bus_rdata_o = DW'(nen_w);
                W_NSOFT: bus_rdata_o = DW'({soft_w, 1'b0});
                W_FSTAT: bus_rdata_o = DW'(fstat_w);
                W_FRAW:  bus_rdata_o = DW'(fraw_w);
                W_FEN:   bus_rdata_o = DW'(fen_w);
                default: bus_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_chk.sv
// Module: irqc_chk
// Property checker for irqc_top, attached by the bind at the end of this file.
// Assumes the master holds select steady until ready is high.
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int WAITS_EFF = 0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src,
    input logic            sel,
    input logic            wr,
    input logic [AW-1:0]   addr,
    input logic [DW-1:0]   wdata,
    input logic            ready,
    input logic [NSRC-1:0] nraw,
    input logic [NSRC-1:0] nen,
    input logic            fraw,
    input logic            fen,
    input logic            irq_n,
    input logic            fiq_n
);

    logic [CNT_W:0] gap_q;

    // Independent count of wait cycles seen in the current access.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_q <= '0;
        else if (sel && !ready)  gap_q <= gap_q + 1'b1;
        else                     gap_q <= '0;
    end

    // R2
    fast_raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> fraw == $past(src[0]));

    // R3
    norm_raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> nraw[NSRC-1:2] == $past(src[NSRC-1:2]));

    // R4
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_n == !(|$past(nraw & nen)));

    // R5
    fiq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> fiq_n == !($past(fraw & fen)));

    // R6
    enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && ready && addr[AW-1:2] == W_NCLR)
        |=> (nen & $past(wdata[NSRC-1:0])) == '0);

    // R8
    wait_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> gap_q == (CNT_W+1)'(WAITS_EFF));

endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .WAITS_EFF(WAITS_EFF)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src_i),
    .sel   (bus_sel_i),
    .wr    (bus_wr_i),
    .addr  (bus_addr_i),
    .wdata (bus_wdata_i),
    .ready (bus_ready_o),
    .nraw  (nraw_w),
    .nen   (nen_w),
    .fraw  (fraw_w),
    .fen   (fen_w),
    .irq_n (irq_n_o),
    .fiq_n (fiq_n_o)
);

// File: tb/irqc_top_test.sv
// Bench: sweeps a small configuration (8 lines, 3 wait states) with
// arithmetic expectations, plus a second instance with an out-of-range
// wait count.
module irqc_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int WS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready, irq_n, fiq_n;

    logic        sel2 = 1'b0;
    logic [31:0] rdata2;
    logic        ready2, irq_n2, fiq_n2;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top #(.NSRC(N), .WAITS(WS)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .bus_ready_o(ready), .irq_n_o(irq_n), .fiq_n_o(fiq_n)
    );

    irqc_top #(.NSRC(N), .WAITS(40)) uut_oor (
        .clk(clk), .rst_n(rst_n), .src_i('0),
        .bus_sel_i(sel2), .bus_wr_i(1'b0), .bus_addr_i(9'h004), .bus_wdata_i('0),
        .bus_rdata_o(rdata2), .bus_ready_o(ready2), .irq_n_o(irq_n2), .fiq_n_o(fiq_n2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access on uut; returns read data and the wait cycles seen.
    task automatic acc(input logic w, input logic [8:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d; waits = 0;
        #1;
        while (!ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rd = rdata;
        @(posedge clk);
        #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        logic [31:0] rd; int w;
        acc(1'b1, a, d, rd, w);
    endtask

    task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] rd; int w;
        acc(1'b0, a, 32'h0, rd, w);
        check(req, rd, exp);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w;
        logic [7:0] en_exp;
        logic [7:0] masks [4] = '{8'h00, 8'hFF, 8'hAA, 8'h55};

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle in reset
        check("R1 irq_n in reset", {31'b0, irq_n}, 32'h1);
        check("R1 fiq_n in reset", {31'b0, fiq_n}, 32'h1);
        rst_n = 1'b1;
        foreach (masks[i]) begin end
        // R1: every register reads 0 after reset
        for (int i = 0; i < 9; i++) begin
            logic [8:0] a;
            a = (i < 5) ? 9'(i*4) : 9'(9'h100 + (i-5)*4);
            rd_chk("R1 register after reset", a, 32'h0);
        end

        // R8: exact wait-state count
        acc(1'b0, 9'h004, 32'h0, rd, w);
        check("R8 wait cycles", 32'(w), 32'(WS));

        // R9: out-of-range wait count means zero waits
        @(negedge clk);
        sel2 = 1'b1;
        #1;
        check("R9 ready with no wait", {31'b0, ready2}, 32'h1);
        check("R9 read data", rdata2, 32'h0);
        @(posedge clk);
        #1 sel2 = 1'b0;

        // R2/R5: fast path from line 0
        src = 8'h01;
        settle();
        rd_chk("R2 fast raw", 9'h104, 32'h1);
        rd_chk("R2 normal raw lane 0", 9'h004, 32'h0);
        rd_chk("R5 fast status disabled", 9'h100, 32'h0);
        check("R5 fiq_n disabled", {31'b0, fiq_n}, 32'h1);
        check("R2 irq_n untouched", {31'b0, irq_n}, 32'h1);
        wr_reg(9'h108, 32'h1);
        settle();
        rd_chk("R6 fast enable set", 9'h108, 32'h1);
        rd_chk("R5 fast status", 9'h100, 32'h1);
        check("R5 fiq_n asserted", {31'b0, fiq_n}, 32'h0);
        wr_reg(9'h10C, 32'h1);
        settle();
        rd_chk("R6 fast enable cleared", 9'h108, 32'h0);
        check("R5 fiq_n released", {31'b0, fiq_n}, 32'h1);
        rd_chk("R6 fast clear reads 0", 9'h10C, 32'h0);

        // R6: set ORs in, clear removes, lane 0 stays 0
        wr_reg(9'h008, 32'h0F);
        rd_chk("R6 set first", 9'h008, 32'h0E);
        wr_reg(9'h008, 32'hF0);
        rd_chk("R6 set ORs", 9'h008, 32'hFE);
        wr_reg(9'h00C, 32'h3C);
        rd_chk("R6 clear", 9'h008, 32'hC2);
        rd_chk("R6 normal clear reads 0", 9'h00C, 32'h0);

        // R3/R4/R5: every line pattern against several enable masks
        wr_reg(9'h108, 32'h1);
        for (int m = 0; m < 4; m++) begin
            wr_reg(9'h00C, 32'hFF);
            wr_reg(9'h008, 32'(masks[m]));
            en_exp = masks[m] & 8'hFE;
            rd_chk("R6 sweep enable", 9'h008, 32'(en_exp));
            for (int s = 0; s < 256; s++) begin
                logic [7:0] raw_e, st_e;
                src = 8'(s);
                raw_e = 8'(s) & 8'hFE;
                st_e  = raw_e & en_exp;
                settle();
                check("R4 irq_n level", {31'b0, irq_n}, {31'b0, (st_e == 8'h0)});
                check("R5 fiq_n level", {31'b0, fiq_n}, {31'b0, ~src[0]});
                rd_chk("R3 normal raw", 9'h004, 32'(raw_e));
                rd_chk("R4 normal status", 9'h000, 32'(st_e));
            end
        end
        wr_reg(9'h10C, 32'h1);

        // R7: soft bit ORed into raw lane 1
        src = 8'h00;
        wr_reg(9'h00C, 32'hFF);
        wr_reg(9'h008, 32'hFE);
        wr_reg(9'h010, 32'h2);
        settle();
        rd_chk("R7 soft sets raw", 9'h004, 32'h2);
        rd_chk("R7 soft readback", 9'h010, 32'h2);
        check("R7 soft raises irq", {31'b0, irq_n}, 32'h0);
        src = 8'h02;
        wr_reg(9'h010, 32'h0);
        settle();
        rd_chk("R7 line keeps lane 1", 9'h004, 32'h2);
        src = 8'h00;
        settle();
        rd_chk("R7 soft cleared", 9'h004, 32'h0);
        check("R7 irq released", {31'b0, irq_n}, 32'h1);
        wr_reg(9'h010, 32'hFD);
        settle();
        rd_chk("R7 only bit 1 matters", 9'h004, 32'h0);

        // R10: unmapped offsets
        wr_reg(9'h0FC, 32'hFFFF_FFFF);
        wr_reg(9'h014, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped read", 9'h0FC, 32'h0);
        rd_chk("R10 unmapped read 2", 9'h014, 32'h0);
        rd_chk("R10 enable unchanged", 9'h008, 32'hFE);
        rd_chk("R10 soft unchanged", 9'h010, 32'h0);
        rd_chk("R10 fast enable unchanged", 9'h108, 32'h0);

        // R11: two-edge latency from line to request
        @(negedge clk);
        src = 8'h04;
        @(posedge clk); @(negedge clk);
        check("R11 irq_n after one edge", {31'b0, irq_n}, 32'h1);
        @(posedge clk); @(negedge clk);
        check("R11 irq_n after two edges", {31'b0, irq_n}, 32'h0);
        src = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R11 release after one edge", {31'b0, irq_n}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R11 release after two edges", {31'b0, irq_n}, 32'h1);

        // R1: reset mid-run returns everything to idle
        src = 8'hFF;
        wr_reg(9'h108, 32'h1);
        settle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 irq_n after reset", {31'b0, irq_n}, 32'h1);
        check("R1 fiq_n after reset", {31'b0, fiq_n}, 32'h1);
        src = 8'h00;
        rst_n = 1'b1;
        rd_chk("R1 enable after reset", 9'h008, 32'h0);
        rd_chk("R1 fast enable after reset", 9'h108, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule